// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block walks a ring of two-word transmit descriptors in memory and turns the buffers they point to into a byte stream. Software places descriptors at a queue base address, sets the transmit enable, and writes the start bit. The engine then fetches each descriptor in turn. The first word holds the buffer address and the second word holds the status. It reads the buffer a word at a time and hands the bytes to a downstream consumer under a valid/ready handshake.

A frame may span several buffers and ends at a buffer whose last flag is set. After the final buffer of a frame, the engine rewrites the status word of the frame's first descriptor with the used bit set. A descriptor that already carries the used bit stops the walk, so a used dummy descriptor ends the chain. If that stop is reached partway through a frame, the frame is abandoned. Its first descriptor is written back with the used bit and a mid-frame exhaustion flag. Whenever the engine stops, it raises a sticky done bit in its status register.

Top module: `txq_fetch_engine`

## Requirements
- R1: After reset, the control, status and base registers read 0, `mem_req` is low and `out_valid` is low.
- R2: Register map, selected by `reg_addr`: 0 is control, 1 is status, 2 is queue base. A control write with bit 9 set starts the engine only if bit 3 (transmit enable) is also set in that write; otherwise nothing is fetched. Control reads back bit 3 only, and bit 9 always reads 0.
- R3: A descriptor is two words. The word at D holds the buffer byte address, whose low 2 bits are ignored. The word at D+4 is the status: bit 31 used, bit 30 wrap, bit 15 last, bits 10:0 length in bytes. Other status bits do not affect length. Buffer bytes leave in ascending address order, little-endian within each 32-bit word.
- R4: The next descriptor is at D+8, or at the queue base when the current descriptor's wrap bit is set. The base register's low 3 bits read as 0.
- R5: Fetching a descriptor whose used bit is set outside a frame halts the engine, and status bit 5 (done) becomes 1.
- R6: `out_last` is high on the final byte of a buffer whose last bit is set. Frames may span buffers.
- R7: When the last buffer of a frame has been sent, the status word of that frame's first descriptor is rewritten as its original value with bit 31 set. The engine then continues with the next descriptor.
- R8: If a used descriptor is fetched while a frame is open, the first descriptor's status is rewritten with bits 31 and 27 set. No `out_last` is produced for that frame, the engine halts, and done is set.
- R9: Done is cleared by writing 1 to status bit 5. Writing 0 leaves it unchanged. A halt in the same cycle wins over the clear.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R11: A buffer of length 0 sends no bytes but still counts as part of the frame and follows its last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 base) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| out_valid | output | 1 | Byte stream valid |
| out_data | output | 8 | Byte stream data |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Byte stream ready |

## Verification
The main walk is driven by a table of two-buffer chains. The chains mix a single-buffer frame, a frame that spans both buffers, a zero-length first buffer, and junk bits in the status word next to the length field. Each chain is run both with a free-flowing consumer and with a stalling consumer. Together these tell frame boundaries apart from buffer boundaries, show that write-back lands on the first descriptor rather than the last, show that the length mask is respected, and show that backpressure neither loses nor repeats bytes. Directed runs then cover a mid-frame stop, the wrap back to the queue base, a start without enable, and the write-one-to-clear rule of done.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned LEN_W    = 11;
    localparam int unsigned BIT_USED = 31;
    localparam int unsigned BIT_WRAP = 30;
    localparam int unsigned BIT_MID  = 27;
    localparam int unsigned BIT_LAST = 15;
    localparam int unsigned BIT_TXEN = 3;
    localparam int unsigned BIT_GO   = 9;
    localparam int unsigned BIT_DONE = 5;

    localparam logic [1:0] RSEL_CTRL = 2'd0;
    localparam logic [1:0] RSEL_STAT = 2'd1;
    localparam logic [1:0] RSEL_BASE = 2'd2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GET_PTR,
        SQ_GET_STAT,
        SQ_GET_WORD,
        SQ_EMIT,
        SQ_RETIRE
    } seq_state_e;

    typedef struct packed {
        logic             used;
        logic             wrap;
        logic             last;
        logic [LEN_W-1:0] len;
    } desc_flags_t;

    function automatic desc_flags_t unpack_status(input logic [WORD_W-1:0] w);
        desc_flags_t f;
        f.used = w[BIT_USED];
        f.wrap = w[BIT_WRAP];
        f.last = w[BIT_LAST];
        f.len  = w[LEN_W-1:0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] retire_word(input logic [WORD_W-1:0] orig,
                                                      input logic abandoned);
        logic [WORD_W-1:0] w;
        w = orig;
        w[BIT_USED] = 1'b1;
        if (abandoned) w[BIT_MID] = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/txq_regs.sv
module txq_regs
    import txq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              halt_pulse,
    output logic              go_pulse,
    output logic [AW-1:0]     qbase
);

    logic tx_en_q;
    logic done_q;
    logic done_clr;

    assign go_pulse = reg_wr && (reg_addr == RSEL_CTRL)
                      && reg_wdata[BIT_GO] && reg_wdata[BIT_TXEN];
    assign done_clr = reg_wr && (reg_addr == RSEL_STAT) && reg_wdata[BIT_DONE];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_en_q <= 1'b0;
            done_q  <= 1'b0;
            qbase   <= '0;
        end else begin
            if (reg_wr && reg_addr == RSEL_CTRL) tx_en_q <= reg_wdata[BIT_TXEN];
            if (reg_wr && reg_addr == RSEL_BASE) qbase <= {reg_wdata[AW-1:3], 3'b000};
            if (halt_pulse)    done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RSEL_CTRL: reg_rdata[BIT_TXEN] = tx_en_q;
            RSEL_STAT: reg_rdata[BIT_DONE] = done_q;
            RSEL_BASE: reg_rdata[AW-1:0]   = qbase;
            default:   reg_rdata = '0;
        endcase
    end

    a_r5_done_after_halt: assert property (@(posedge clk) disable iff (rst)
        halt_pulse |=> done_q);

    a_r9_done_w1c: assert property (@(posedge clk) disable iff (rst)
        (done_clr && !halt_pulse) |=> !done_q);

endmodule

// File: rtl/txq_byte_pick.sv
module txq_byte_pick #(
    parameter int unsigned BYTES  = 4,
    localparam int unsigned SEL_W = $clog2(BYTES)
) (
    input  logic [8*BYTES-1:0] word,
    input  logic [SEL_W-1:0]   sel,
    output logic [7:0]         data
);

    logic [7:0] lanes [BYTES];

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign lanes[g] = word[8*g +: 8];
    end

    assign data = lanes[sel];

endmodule

// File: rtl/txq_sequencer.sv
module txq_sequencer
    import txq_pkg::*;
#(
    parameter int unsigned AW = 32,
    localparam int unsigned BYTES = WORD_W / 8,
    localparam int unsigned SEL_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_pulse,
    input  logic [AW-1:0]     qbase,
    output logic              halt_pulse,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready
);

    localparam logic [AW-1:0] DESC_STEP = AW'(8);
    localparam logic [AW-1:0] STAT_OFS  = AW'(4);
    localparam logic [AW-1:0] WORD_STEP = AW'(BYTES);

    seq_state_e        state;
    logic [AW-1:0]     cur_desc;
    logic [AW-1:0]     buf_ptr;
    logic [AW-1:0]     first_desc;
    logic [WORD_W-1:0] first_stat;
    desc_flags_t       flags;
    logic [LEN_W-1:0]  remain;
    logic [WORD_W-1:0] word_q;
    logic [SEL_W-1:0]  lane;
    logic              in_frame;
    logic              abandon;
    desc_flags_t       fetched;
    logic [AW-1:0]     next_desc;

    assign fetched   = unpack_status(mem_rdata);
    assign next_desc = flags.wrap ? qbase : cur_desc + DESC_STEP;

    txq_byte_pick #(.BYTES(BYTES)) u_pick (
        .word (word_q),
        .sel  (lane),
        .data (out_data)
    );

    assign out_valid = (state == SQ_EMIT);
    assign out_last  = out_valid && flags.last && (remain == LEN_W'(1));

    assign halt_pulse = mem_ack && (
        (state == SQ_GET_STAT && fetched.used && !in_frame) ||
        (state == SQ_RETIRE && abandon));

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        case (state)
            SQ_GET_PTR:  mem_req = 1'b1;
            SQ_GET_STAT: begin
                mem_req  = 1'b1;
                mem_addr = cur_desc + STAT_OFS;
            end
            SQ_GET_WORD: begin
                mem_req  = 1'b1;
                mem_addr = buf_ptr;
            end
            SQ_RETIRE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_desc + STAT_OFS;
                mem_wdata = retire_word(first_stat, abandon);
            end
            default: mem_req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_IDLE;
            cur_desc   <= '0;
            buf_ptr    <= '0;
            first_desc <= '0;
            first_stat <= '0;
            flags      <= '0;
            remain     <= '0;
            word_q     <= '0;
            lane       <= '0;
            in_frame   <= 1'b0;
            abandon    <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (go_pulse) begin
                        cur_desc <= qbase;
                        in_frame <= 1'b0;
                        state    <= SQ_GET_PTR;
                    end
                end
                SQ_GET_PTR: begin
                    if (mem_ack) begin
                        buf_ptr <= {mem_rdata[AW-1:2], 2'b00};
                        state   <= SQ_GET_STAT;
                    end
                end
                SQ_GET_STAT: begin
                    if (mem_ack) begin
                        flags  <= fetched;
                        remain <= fetched.len;
                        lane   <= '0;
                        if (fetched.used) begin
                            abandon <= in_frame;
                            state   <= in_frame ? SQ_RETIRE : SQ_IDLE;
                        end else begin
                            abandon <= 1'b0;
                            if (!in_frame) begin
                                first_desc <= cur_desc;
                                first_stat <= mem_rdata;
                                in_frame   <= 1'b1;
                            end
                            if (fetched.len != '0) begin
                                state <= SQ_GET_WORD;
                            end else if (fetched.last) begin
                                state <= SQ_RETIRE;
                            end else begin
                                cur_desc <= fetched.wrap ? qbase : cur_desc + DESC_STEP;
                                state    <= SQ_GET_PTR;
                            end
                        end
                    end
                end
                SQ_GET_WORD: begin
                    if (mem_ack) begin
                        word_q  <= mem_rdata;
                        lane    <= '0;
                        buf_ptr <= buf_ptr + WORD_STEP;
                        state   <= SQ_EMIT;
                    end
                end
                SQ_EMIT: begin
                    if (out_ready) begin
                        remain <= remain - LEN_W'(1);
                        lane   <= lane + SEL_W'(1);
                        if (remain == LEN_W'(1)) begin
                            if (flags.last) begin
                                state <= SQ_RETIRE;
                            end else begin
                                cur_desc <= next_desc;
                                state    <= SQ_GET_PTR;
                            end
                        end else if (lane == SEL_W'(BYTES - 1)) begin
                            state <= SQ_GET_WORD;
                        end
                    end
                end
                SQ_RETIRE: begin
                    if (mem_ack) begin
                        in_frame <= 1'b0;
                        if (abandon) begin
                            state <= SQ_IDLE;
                        end else begin
                            cur_desc <= next_desc;
                            state    <= SQ_GET_PTR;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    a_r10_hold_stream: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    a_r3_req_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=>
            (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && !go_pulse) |=> !mem_req);

endmodule

// File: rtl/txq_fetch_engine.sv
module txq_fetch_engine
    import txq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_last,
    input  logic              out_ready
);

    logic          go_pulse;
    logic          halt_pulse;
    logic [AW-1:0] qbase;

    txq_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .halt_pulse (halt_pulse),
        .go_pulse   (go_pulse),
        .qbase      (qbase)
    );

    txq_sequencer #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go_pulse   (go_pulse),
        .qbase      (qbase),
        .halt_pulse (halt_pulse),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_ready  (out_ready)
    );

endmodule

// File: tb/tb_txq_fetch_engine.sv
module tb_txq_fetch_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        out_valid, out_last;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;

    always #5 clk = ~clk;

    txq_fetch_engine #(.AW(32)) dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
    );

    logic [31:0] mem [512];
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[10:2]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    logic [7:0] cap_d [256];
    logic       cap_l [256];
    int         ncap = 0;
    int         req_seen = 0;
    always @(posedge clk) begin
        if (out_valid && out_ready) begin
            cap_d[ncap[7:0]] <= out_data;
            cap_l[ncap[7:0]] <= out_last;
            ncap <= ncap + 1;
        end
        if (mem_req) req_seen <= req_seen + 1;
    end

    int   stall_mode = 0;
    int   ncyc = 0;
    int   hold_err = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = 8'd0;
    logic prev_last = 1'b0;
    always @(negedge clk) begin
        ncyc <= ncyc + 1;
        if (prev_stall && (out_valid !== 1'b1 || out_data !== prev_data || out_last !== prev_last))
            hold_err <= hold_err + 1;
        out_ready = (stall_mode == 0) ? 1'b1 : ((ncyc % 3) != 0);
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        prev_last  = out_last;
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_engine(input logic [31:0] base, output logic [31:0] stat);
        int n;
        wr(2'd2, base);
        wr(2'd0, 32'h0000_0208);
        n = 0;
        do begin
            rd(2'd1, stat);
            n++;
        end while (!stat[5] && n < 5000);
        repeat (3) @(negedge clk);
    endtask

    task automatic put_byte(input int addr, input logic [7:0] v);
        mem[addr >> 2][8*(addr % 4) +: 8] = v;
    endtask

    function automatic logic [7:0] pat(input int v, input int b, input int i);
        return 8'((v * 37) + (b * 100) + (i * 3) + 1);
    endfunction

    localparam int NV = 5;
    localparam int VA_LEN  [NV] = '{5, 6, 0, 9, 4};
    localparam int VA_LAST [NV] = '{1, 0, 0, 1, 0};
    localparam int VB_LEN  [NV] = '{3, 4, 7, 1, 2};
    localparam int V_JUNK  [NV] = '{0, 0, 0, 1, 1};
    localparam int V_STALL [NV] = '{0, 1, 0, 1, 1};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, sa, sb, st;
        for (int i = 0; i < 512; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(2'd0, r); check(r == 0, "R1 ctrl", r, 0);
        rd(2'd1, r); check(r == 0, "R1 stat", r, 0);
        rd(2'd2, r); check(r == 0, "R1 base", r, 0);
        check(mem_req == 1'b0 && out_valid == 1'b0, "R1 idle outputs",
              {30'd0, mem_req, out_valid}, 0);

        // R2: go without transmit enable is ignored
        mem[32'h100 >> 2] = 32'h400;
        mem[32'h104 >> 2] = 32'h0000_8003;
        wr(2'd2, 32'h100);
        req_seen = 0;
        wr(2'd0, 32'h0000_0200);
        repeat (20) @(negedge clk);
        check(req_seen == 0, "R2 no fetch without enable", req_seen, 0);
        rd(2'd1, r); check(r[5] == 1'b0, "R2 done stays clear", r, 0);
        rd(2'd0, r); check(r == 0, "R2 ctrl readback", r, 0);

        // R3 R6 R7 R11 R10: table of two-buffer chains
        for (int v = 0; v < NV; v++) begin
            int exp_n;
            int bad_d;
            int bad_l;
            stall_mode = V_STALL[v];
            for (int i = 0; i < 512; i++) mem[i] = 32'd0;
            for (int i = 0; i < VA_LEN[v]; i++) put_byte(32'h400 + i, pat(v, 0, i));
            for (int i = 0; i < VB_LEN[v]; i++) put_byte(32'h600 + i, pat(v, 1, i));
            sa = 32'(VA_LEN[v]) | (VA_LAST[v] != 0 ? 32'h8000 : 32'h0) |
                 (V_JUNK[v] != 0 ? 32'h0000_5800 : 32'h0);
            sb = 32'(VB_LEN[v]) | 32'h8000 | (V_JUNK[v] != 0 ? 32'h0000_1000 : 32'h0);
            mem[32'h100 >> 2] = 32'h0000_0401;
            mem[32'h104 >> 2] = sa;
            mem[32'h108 >> 2] = 32'h0000_0603;
            mem[32'h10C >> 2] = sb;
            mem[32'h114 >> 2] = 32'h8000_8000;
            ncap = 0;
            hold_err = 0;
            run_engine(32'h100, st);
            exp_n = VA_LEN[v] + VB_LEN[v];
            check(st[5] == 1'b1, "R5 done after used stop", st, 32'h20);
            check(ncap == exp_n, "R3 byte count", ncap, exp_n);
            bad_d = 0;
            bad_l = 0;
            for (int i = 0; i < exp_n && i < ncap; i++) begin
                logic [7:0] e;
                logic el;
                e  = (i < VA_LEN[v]) ? pat(v, 0, i) : pat(v, 1, i - VA_LEN[v]);
                el = (i == exp_n - 1) || (VA_LAST[v] != 0 && i == VA_LEN[v] - 1);
                if (cap_d[i] !== e)  bad_d++;
                if (cap_l[i] !== el) bad_l++;
            end
            check(bad_d == 0, "R3 byte order and value", bad_d, 0);
            check(bad_l == 0, "R6 last marking", bad_l, 0);
            check(mem[32'h104 >> 2] == (sa | 32'h8000_0000), "R7 first descriptor retired",
                  mem[32'h104 >> 2], sa | 32'h8000_0000);
            check(mem[32'h10C >> 2] == (VA_LAST[v] != 0 ? (sb | 32'h8000_0000) : sb),
                  "R7 second descriptor write-back", mem[32'h10C >> 2],
                  VA_LAST[v] != 0 ? (sb | 32'h8000_0000) : sb);
            check(hold_err == 0, "R10 stall hold", hold_err, 0);
            wr(2'd1, 32'h20);
        end
        stall_mode = 0;

        // R9: write 0 keeps done, write 1 clears it
        rd(2'd1, r); check(r[5] == 1'b0, "R9 cleared by writing one", r, 0);
        mem[32'h104 >> 2] = 32'h8000_0000;
        run_engine(32'h100, st);
        wr(2'd1, 32'h0);
        rd(2'd1, r); check(r[5] == 1'b1, "R9 write zero keeps done", r, 32'h20);
        wr(2'd1, 32'h20);
        rd(2'd1, r); check(r[5] == 1'b0, "R9 write one clears", r, 0);

        // R8: used descriptor inside an open frame
        for (int i = 0; i < 512; i++) mem[i] = 32'd0;
        for (int i = 0; i < 3; i++) put_byte(32'h400 + i, pat(9, 0, i));
        mem[32'h100 >> 2] = 32'h400;
        mem[32'h104 >> 2] = 32'h0000_0003;
        mem[32'h10C >> 2] = 32'h8000_8000;
        ncap = 0;
        run_engine(32'h100, st);
        check(st[5] == 1'b1, "R8 done on abandon", st, 32'h20);
        check(ncap == 3, "R8 bytes before abandon", ncap, 3);
        check(cap_l[0] == 1'b0 && cap_l[1] == 1'b0 && cap_l[2] == 1'b0, "R8 no last marker",
              {29'd0, cap_l[2], cap_l[1], cap_l[0]}, 0);
        check(mem[32'h104 >> 2] == 32'h8800_0003, "R8 first descriptor flagged",
              mem[32'h104 >> 2], 32'h8800_0003);
        wr(2'd1, 32'h20);

        // R4: wrap returns to base; base low bits drop
        for (int i = 0; i < 512; i++) mem[i] = 32'd0;
        mem[32'h180 >> 2] = 32'h400;
        mem[32'h184 >> 2] = 32'h0000_8002;
        mem[32'h188 >> 2] = 32'h600;
        mem[32'h18C >> 2] = 32'h4000_8002;
        mem[32'h190 >> 2] = 32'h500;
        mem[32'h194 >> 2] = 32'h0000_8005;
        ncap = 0;
        run_engine(32'h187, st);
        rd(2'd2, r); check(r == 32'h180, "R4 base alignment", r, 32'h180);
        check(ncap == 4, "R4 wrap to base", ncap, 4);
        check(mem[32'h18C >> 2] == 32'hC000_8002, "R4 wrapped descriptor retired",
              mem[32'h18C >> 2], 32'hC000_8002);
        check(mem[32'h194 >> 2] == 32'h0000_8005, "R4 descriptor past wrap untouched",
              mem[32'h194 >> 2], 32'h0000_8005);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule